// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block moves an 8-bit processor's context to and from its stack. The processor has a 16-bit stack pointer and a memory that is one word wide. When the core accepts an interrupt, the block takes the current program counter, condition-code byte and stack pointer. It then writes two stack words below the stack pointer: the program counter word first and the condition-code word second. The condition-code byte fills both halves of its word. The new stack pointer comes out as the old value minus four.

A return-from-exception request runs the same steps in reverse. The block reads the condition-code word at the stack pointer and then the program counter word two bytes above it. Only the even-address (upper) byte of the condition-code word is restored; the odd-address copy is dropped. The stack pointer comes back raised by four. Every access is a whole word at an even address, and each one waits on the memory's ready handshake. A one-cycle done pulse marks the end of a sequence. If the stack pointer is odd, the block flags an alignment error and touches no memory.

Top module: `ctx_stack_seq`

## Requirements
- R1: On an interrupt strobe with an even stack pointer SP, the block writes the PC word at SP-2 and then the CCR word at SP-4, in that order, with write enable high.
- R2: The memory port is big-endian, so bits [15:8] are the even byte. The CCR word is written as {CCR, CCR}. The PC word is written with PC[15:8] in bits [15:8].
- R3: After a save, the stack-pointer output is SP-4. After a return, it is SP+4. Both are taken modulo 2^16.
- R4: On a return strobe, the block reads SP and then SP+2 with write enable low. The restored CCR is bits [15:8] of the first word, and bits [7:0] of that word have no effect. The restored PC is the whole second word.
- R5: Every memory request carries an even address.
- R6: A request stays asserted until ready is high at a clock edge. Its address, write enable and write data stay stable while it waits. With a ready latency of L cycles per access, done rises 2L+2 cycles after the strobe edge.
- R7: Done is a single-cycle pulse that comes after the second access completes. The PC, CCR and SP outputs are valid in that cycle and hold their values afterwards.
- R8: A strobe with an odd stack pointer raises the alignment error for exactly one cycle, in the cycle after the strobe. It makes no memory access, gives no done pulse and does not change the outputs.
- R9: Busy is high from the cycle after an accepted strobe up to and including the done cycle. Any strobe that arrives while busy is high is ignored.
- R10: If both strobes are high in the same cycle, the save sequence runs.
- R11: While reset is active, busy, done, the request, the alignment error and the PC, CCR and SP outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Interrupt accepted strobe (starts a save) |
| rte_req | input | 1 | Return strobe (starts a restore) |
| cur_pc | input | 16 | Program counter to save |
| cur_ccr | input | 8 | Condition-code byte to save |
| cur_sp | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable of the request |
| mem_addr | output | 16 | Byte address of the word (always even) |
| mem_wdata | output | 16 | Write data, bits [15:8] at the even byte |
| mem_rdata | input | 16 | Read data, bits [15:8] from the even byte |
| mem_ready | input | 1 | Access completes at an edge where this and mem_req are high |
| new_pc | output | 16 | Saved or restored program counter |
| new_ccr | output | 8 | Saved or restored condition-code byte |
| new_sp | output | 16 | Updated stack pointer |
| done | output | 1 | One-cycle end-of-sequence pulse |
| busy | output | 1 | A sequence is running |
| align_err | output | 1 | One-cycle pulse for an odd stack pointer |

## Verification
The bench uses the package defaults: 8-bit bytes, 16-bit words and a 16-bit address. A memory model of 256 words is indexed by address bits [8:1]. The bench sweeps memory ready latencies 0 to 2 across several stack pointers and pairs each save with a return. Before each return, it corrupts the odd byte of the stacked CCR word, which shows that only the even byte is reloaded. The small address space also allows a return at the top of memory, where SP+4 wraps to zero. Further runs cover odd stack pointers, both strobes arriving together, and strobes sent mid-sequence.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
    parameter int BYTE_W = 8;
    parameter int WORD_W = 2 * BYTE_W;
    parameter int ADDR_W = 16;
    localparam int WORD_BYTES  = WORD_W / BYTE_W;
    localparam int FRAME_BYTES = 2 * WORD_BYTES;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ACC0, ST_ACC1, ST_FIN} seq_state_e;
    typedef enum logic {OP_SAVE, OP_RESTORE} seq_op_e;

    typedef struct packed {
        word_t pc;
        byte_t ccr;
        addr_t sp;
    } ctx_t;

    // Address of one stack word for a given direction and access index.
    function automatic addr_t slot_addr(addr_t base, seq_op_e op, logic second);
        if (op == OP_SAVE)
            return second ? base - addr_t'(FRAME_BYTES) : base - addr_t'(WORD_BYTES);
        else
            return second ? base + addr_t'(WORD_BYTES) : base;
    endfunction

    function automatic word_t dup_byte(byte_t b);
        return {b, b};
    endfunction

    function automatic byte_t even_byte(word_t w);
        return w[WORD_W-1 -: BYTE_W];
    endfunction
endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_take,
    input  logic       rte_req,
    input  logic       sp_odd,
    input  logic       mem_ready,
    output seq_state_e state,
    output seq_op_e    op,
    output logic       start,
    output logic       align_err
);
    logic any_strobe;

    always_comb begin
        any_strobe = irq_take | rte_req;
        start      = (state == ST_IDLE) && any_strobe && !sp_odd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op        <= OP_SAVE;
            align_err <= 1'b0;
        end else begin
            align_err <= (state == ST_IDLE) && any_strobe && sp_odd;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ACC0;
                    op    <= irq_take ? OP_SAVE : OP_RESTORE;
                end
                ST_ACC0: if (mem_ready) state <= ST_ACC1;
                ST_ACC1: if (mem_ready) state <= ST_FIN;
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
    import ctx_stack_pkg::*;
(
    input  ctx_t       work,
    input  seq_op_e    op,
    input  seq_state_e state,
    output addr_t      mem_addr,
    output logic       mem_we,
    output word_t      mem_wdata
);
    logic second;

    always_comb begin
        second   = (state == ST_ACC1);
        mem_addr = slot_addr(work.sp, op, second);
        mem_we   = (op == OP_SAVE);
        if (op == OP_SAVE)
            mem_wdata = second ? dup_byte(work.ccr) : work.pc;
        else
            mem_wdata = '0;
    end
endmodule

// File: rtl/ctx_frame_reg.sv
module ctx_frame_reg
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  ctx_t       cur,
    input  seq_op_e    op,
    input  seq_state_e state,
    input  logic       mem_ready,
    input  word_t      mem_rdata,
    output ctx_t       work,
    output ctx_t       result
);
    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            result <= '0;
        end else begin
            if (start)
                work <= cur;
            if (state == ST_ACC0 && mem_ready && op == OP_RESTORE)
                work.ccr <= even_byte(mem_rdata);
            if (state == ST_ACC1 && mem_ready) begin
                result.pc  <= (op == OP_RESTORE) ? mem_rdata : work.pc;
                result.ccr <= work.ccr;
                result.sp  <= (op == OP_SAVE) ? work.sp - addr_t'(FRAME_BYTES)
                                              : work.sp + addr_t'(FRAME_BYTES);
            end
        end
    end
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_take,
    input  logic              rte_req,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [BYTE_W-1:0] cur_ccr,
    input  logic [ADDR_W-1:0] cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [WORD_W-1:0] new_pc,
    output logic [BYTE_W-1:0] new_ccr,
    output logic [ADDR_W-1:0] new_sp,
    output logic              done,
    output logic              busy,
    output logic              align_err
);
    seq_state_e state;
    seq_op_e    op;
    logic       start;
    ctx_t       cur, work, result;

    assign cur = '{pc: cur_pc, ccr: cur_ccr, sp: cur_sp};

    ctx_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .irq_take(irq_take), .rte_req(rte_req),
        .sp_odd(cur_sp[0]), .mem_ready(mem_ready),
        .state(state), .op(op), .start(start), .align_err(align_err)
    );

    ctx_addr_gen u_addr (
        .work(work), .op(op), .state(state),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    ctx_frame_reg u_frame (
        .clk(clk), .rst(rst), .start(start), .cur(cur), .op(op),
        .state(state), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .work(work), .result(result)
    );

    always_comb begin
        mem_req = (state == ST_ACC0) || (state == ST_ACC1);
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        new_pc  = result.pc;
        new_ccr = result.ccr;
        new_sp  = result.sp;
    end
endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk
    import ctx_stack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              done,
    input logic              busy,
    input logic              align_err
);
    // R5: only even word addresses reach memory
    a_r5_even_addr: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);

    // R6: a waiting request holds steady
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: alignment error comes with no activity
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        align_err |-> (!mem_req && !busy && !done));

    // R9: no memory traffic outside a sequence
    a_r9_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R7: done comes only after the last access completes
    a_r7_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_req && mem_ready));
endmodule

bind ctx_stack_seq ctx_stack_seq_chk u_chk (.*);

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst, irq_take, rte_req;
    logic [15:0] cur_pc, cur_sp;
    logic [7:0]  cur_ccr;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] new_pc, new_sp;
    logic [7:0]  new_ccr;
    logic        done, busy, align_err;

    ctx_stack_seq uut (
        .clk(clk), .rst(rst), .irq_take(irq_take), .rte_req(rte_req),
        .cur_pc(cur_pc), .cur_ccr(cur_ccr), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .new_pc(new_pc), .new_ccr(new_ccr), .new_sp(new_sp),
        .done(done), .busy(busy), .align_err(align_err)
    );

    logic [15:0] mem [0:255];
    int          lat;
    int          cnt;
    bit          took;
    int          acc_n;
    logic [15:0] acc_addr [0:7];
    logic        acc_we   [0:7];
    int          checks, fails;
    bit          finished;

    function automatic logic [7:0] widx(input logic [15:0] a);
        return a[8:1];
    endfunction

    assign mem_rdata = mem[mem_addr[8:1]];

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (acc_n < 8) begin
                acc_addr[acc_n] = mem_addr;
                acc_we[acc_n]   = mem_we;
            end
            acc_n = acc_n + 1;
            if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
            took = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (took) begin cnt = 0; took = 1'b0; end
        if (!mem_req) begin
            cnt = 0;
            mem_ready = 1'b0;
        end else begin
            mem_ready = (cnt >= lat);
            if (!mem_ready) cnt = cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Save sequence; poke sends extra strobes mid-sequence, both raises both strobes at start
    task automatic run_save(input logic [15:0] sp, input logic [15:0] pc, input logic [7:0] ccr,
                            input bit poke, input bit both);
        int  cyc;
        bit  got;
        bit  drop;
        @(negedge clk);
        acc_n = 0;
        cur_sp = sp; cur_pc = pc; cur_ccr = ccr;
        irq_take = 1'b1; rte_req = both;
        @(negedge clk);
        irq_take = 1'b0; rte_req = 1'b0;
        chk(busy === 1'b1, "R9 busy after strobe", busy, 1);
        cyc = 0; got = 0; drop = 0;
        while (!got && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1) begin irq_take = 1'b1; rte_req = 1'b1; end
            else begin irq_take = 1'b0; rte_req = 1'b0; end
            if (done) got = 1;
            else if (!busy) drop = 1;
        end
        irq_take = 1'b0; rte_req = 1'b0;
        chk(got && !drop, "R7 done seen with busy held (R9)", {got, drop}, 2'b10);
        chk(cyc == 2*lat + 2, "R6 done latency", cyc, 2*lat + 2);
        chk(acc_n == 2, "R9 access count", acc_n, 2);
        chk(acc_addr[0] === sp - 16'd2 && acc_we[0] === 1'b1, "R1 first write at SP-2", acc_addr[0], sp - 16'd2);
        chk(acc_addr[1] === sp - 16'd4 && acc_we[1] === 1'b1, "R1 second write at SP-4", acc_addr[1], sp - 16'd4);
        chk(mem[widx(sp - 16'd4)] === {ccr, ccr}, "R2 CCR word doubled", mem[widx(sp - 16'd4)], {ccr, ccr});
        chk(mem[widx(sp - 16'd2)] === pc, "R2 PC word big-endian", mem[widx(sp - 16'd2)], pc);
        chk(new_sp === sp - 16'd4, "R3 SP after save", new_sp, sp - 16'd4);
        chk(new_pc === pc && new_ccr === ccr, "R7 outputs at done", {new_pc, new_ccr}, {pc, ccr});
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R7 done single pulse", {done, busy}, 0);
        chk(acc_n == 2 && new_sp === sp - 16'd4, "R9 late strobes ignored, R7 hold", acc_n, 2);
    endtask

    task automatic run_rte(input logic [15:0] sp, input logic [15:0] exp_pc, input logic [7:0] exp_ccr);
        int cyc;
        bit got;
        @(negedge clk);
        acc_n = 0;
        cur_sp = sp; cur_pc = 16'hDEAD; cur_ccr = 8'hEE;
        rte_req = 1'b1;
        @(negedge clk);
        rte_req = 1'b0;
        cyc = 0; got = 0;
        while (!got && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (done) got = 1;
        end
        chk(got, "R7 return done", got, 1);
        chk(cyc == 2*lat + 2, "R6 return latency", cyc, 2*lat + 2);
        chk(acc_n == 2 && acc_addr[0] === sp && acc_we[0] === 1'b0, "R4 first read at SP", acc_addr[0], sp);
        chk(acc_addr[1] === sp + 16'd2 && acc_we[1] === 1'b0, "R4 second read at SP+2", acc_addr[1], sp + 16'd2);
        chk(new_ccr === exp_ccr, "R4 CCR from even byte only", new_ccr, exp_ccr);
        chk(new_pc === exp_pc, "R4 PC restored", new_pc, exp_pc);
        chk(new_sp === sp + 16'd4, "R3 SP after return", new_sp, sp + 16'd4);
        @(negedge clk);
        chk(done === 1'b0, "R7 return pulse ends", done, 0);
    endtask

    task automatic run_odd(input logic [15:0] sp, input bit use_irq);
        logic [15:0] prev;
        @(negedge clk);
        acc_n = 0;
        prev = new_sp;
        cur_sp = sp;
        irq_take = use_irq; rte_req = !use_irq;
        @(negedge clk);
        irq_take = 1'b0; rte_req = 1'b0;
        chk(align_err === 1'b1 && busy === 1'b0 && mem_req === 1'b0, "R8 error flagged, no access",
            {align_err, busy, mem_req}, 3'b100);
        @(negedge clk);
        chk(align_err === 1'b0 && done === 1'b0, "R8 error one cycle", {align_err, done}, 0);
        chk(acc_n == 0 && new_sp === prev, "R8 no access, outputs kept", {acc_n[15:0], new_sp}, {16'd0, prev});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] sps [0:3];
        checks = 0; fails = 0; finished = 0;
        lat = 0; cnt = 0; took = 0; acc_n = 0; mem_ready = 0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) begin acc_addr[i] = '0; acc_we[i] = 0; end
        rst = 1'b1; irq_take = 0; rte_req = 0;
        cur_pc = '0; cur_sp = '0; cur_ccr = '0;
        sps[0] = 16'h0004; sps[1] = 16'h0040; sps[2] = 16'h00A2; sps[3] = 16'h01FE;
        repeat (3) @(negedge clk);
        chk({busy, done, mem_req, align_err} === 4'b0, "R11 reset controls", {busy, done, mem_req, align_err}, 0);
        chk({new_pc, new_ccr, new_sp} === 40'b0, "R11 reset outputs", {new_pc, new_sp}, 0);
        rst = 1'b0;

        for (int l = 0; l < 3; l++) begin
            lat = l;
            for (int i = 0; i < 4; i++) begin
                logic [15:0] pc;
                logic [7:0]  ccr;
                pc  = 16'hA000 + 16'(i * 16'h0111) + 16'(l);
                ccr = 8'h3C ^ 8'(i * 17 + l * 5);
                run_save(sps[i], pc, ccr, i == 1, 1'b0);
                // corrupt the odd copy; the return must not see it
                mem[widx(sps[i] - 16'd4)][7:0] = ~ccr;
                run_rte(sps[i] - 16'd4, pc, ccr);
            end
        end

        // R10: both strobes together start a save
        lat = 1;
        run_save(16'h0060, 16'h4321, 8'h81, 1'b0, 1'b1);

        // R3: return at top of memory wraps SP to zero
        lat = 0;
        mem[widx(16'hFFFC)] = {8'h5A, 8'hC3};
        mem[widx(16'hFFFE)] = 16'h1234;
        run_rte(16'hFFFC, 16'h1234, 8'h5A);

        // R8: odd stack pointer on both strobe kinds
        run_odd(16'h0041, 1'b1);
        run_odd(16'h00FF, 1'b0);

        summary();
    end
endmodule